// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block walks a single decoded instruction across a run of vector elements. A 32-bit state word, loaded while the sequencer is idle, holds the vector length and the maximum vector length. When a decoded instruction is accepted, the sequencer captures its operand register numbers and per-operand vector flags. It then issues one element operation per step, with a step counter that starts at zero. Each vector-flagged operand has its register number offset by the current step, and scalar operands keep their base number.

The sequencer waits for a completion pulse from execution after each issue. Only when the last element completes does it raise a program-counter advance request, which comes with a done pulse. A zero vector length retires the instruction at once, without issuing anything. The sequencer also reports when none of the instruction's destination operands is vectorised, so that later logic can handle a scalar result once.

Top module: `vec_elem_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the sequencer goes idle, the step counter and the state word clear to zero, and issue, pc_adv and loop_done stay low.
- R2: The state readout places vector length in bits 6:0, maximum length in bits 14:8, the current step in bits 22:16, and zero elsewhere. A write loads only the two length fields. The step bits of the write data are ignored.
- R3: A state write takes effect only when the sequencer is idle and no instruction is being accepted in the same cycle. A write at any other time leaves the readout unchanged.
- R4: When dec_valid is seen at a clock edge while idle with a nonzero length, issue is high for exactly one cycle after that edge. Each later issue comes one cycle after the edge at which the previous element's completion pulse is sampled. Issue and pc_adv are never high together.
- R5: The step counter takes the values 0 through length minus 1 in order, one per issue. It moves only on an exec_done sampled while waiting for completion. An exec_done at any other time has no effect.
- R6: During issue, each vector-flagged operand's output register number is its base plus the current step, modulo 128. Each scalar operand's output equals its base.
- R7: With a vector length of 0, an accepted instruction issues nothing, and pc_adv and loop_done pulse in the cycle right after acceptance.
- R8: pc_adv and loop_done pulse together for one cycle, right after the completion pulse of the last element. The step counter is back at 0 in that cycle.
- R9: dst_all_scalar is high exactly when none of the captured instruction's destination vector flags is set.
- R10: dec_valid is ignored while the sequencer is busy. The running loop's operands and element count are unchanged by it.

Top module ports follow, with default parameters (3 source and 2 destination operands, 7-bit register numbers).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction present |
| src_vec | input | 3 | Vector flag per source operand |
| dst_vec | input | 2 | Vector flag per destination operand |
| src_base | input | 21 | Source base register numbers, 7 bits each, operand 0 lowest |
| dst_base | input | 14 | Destination base register numbers, 7 bits each, operand 0 lowest |
| st_wr_en | input | 1 | State word write strobe |
| st_wr_data | input | 32 | State word write data |
| exec_done | input | 1 | Element completion pulse from execution |
| issue | output | 1 | Element operation issue strobe |
| src_reg | output | 21 | Offset source register numbers |
| dst_reg | output | 14 | Offset destination register numbers |
| cur_step | output | 7 | Current element step |
| pc_adv | output | 1 | Program counter advance request |
| loop_done | output | 1 | Loop completion pulse |
| dst_all_scalar | output | 1 | No destination operand is vectorised |
| st_rd_data | output | 32 | State word readout |

## Verification
The loop is driven with lengths 0, 1, 3 and 127. These separate the immediate-retire path, the single-element case where the first step is also the last, a short loop, and a full-range loop that runs every step value. Vector-flag mixes of all-scalar, partly vector and a base of 126 tell apart correct per-operand selection, wrong operand masking and a missing modulo-128 wrap. Completion pulses come both back-to-back and after idle gaps. Stray pulses, state writes and new instructions are injected mid-loop to show the counter moves only on a real completion and that busy-time stimulus is dropped.

// File: rtl/vseq_pkg.sv
// Package: shared widths, state-word field positions and the sequencer
// state encoding for the vector element loop sequencer.
package vseq_pkg;
    localparam int STATE_W   = 32;
    localparam int LEN_W     = 7;
    localparam int REG_W     = 7;
    localparam int VL_LSB    = 0;
    localparam int MVL_LSB   = 8;
    localparam int STEP_LSB  = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ISSUE  = 2'd1,
        SEQ_WAIT   = 2'd2,
        SEQ_RETIRE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/vseq_state_reg.sv
// Module: vseq_state_reg
// Holds the vector length and maximum vector length fields of the state
// word. Assumes the caller gates wr_ok so that writes land only while no
// loop is running. Step bits of the write data are never stored here.
module vseq_state_reg #(
    parameter int STATE_W = 32,
    parameter int LEN_W   = 7,
    parameter int VL_LSB  = 0,
    parameter int MVL_LSB = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_ok,
    input  logic [STATE_W-1:0] wr_data,
    output logic [LEN_W-1:0]   vl,
    output logic [LEN_W-1:0]   mvl
);
    // Load or clear the two length fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl  <= '0;
            mvl <= '0;
        end else if (wr_en && wr_ok) begin
            vl  <= wr_data[VL_LSB +: LEN_W];
            mvl <= wr_data[MVL_LSB +: LEN_W];
        end
    end
endmodule

// File: rtl/vseq_step_ctr.sv
// Module: vseq_step_ctr
// Element step counter. Advances by one on 'advance', returns to zero on
// 'clear'. Assumes vl is nonzero whenever 'last' is consumed.
module vseq_step_ctr #(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             clear,
    input  logic [LEN_W-1:0] vl,
    output logic [LEN_W-1:0] step,
    output logic             last
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    // Step register: clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            step <= '0;
        end else if (advance) begin
            step <= step + ONE;
        end
    end

    // Final-element detection against the length field.
    always_comb begin
        last = (step == (vl - ONE));
    end
endmodule

// File: rtl/vseq_reg_offset.sv
// Module: vseq_reg_offset
// Adds the element step to one operand's base register number when the
// operand is flagged as vector; wraps modulo 2**REG_W.
module vseq_reg_offset #(
    parameter int REG_W = 7,
    parameter int LEN_W = 7
) (
    input  logic [REG_W-1:0] base,
    input  logic             is_vec,
    input  logic [LEN_W-1:0] step,
    output logic [REG_W-1:0] reg_num
);
    logic [REG_W-1:0] step_ext;

    // Resize step to register width and select offset or base.
    always_comb begin
        step_ext = REG_W'(step);
        reg_num  = is_vec ? (base + step_ext) : base;
    end
endmodule

// File: rtl/vec_elem_seq.sv
// Module: vec_elem_seq (top)
// Steps one decoded instruction over VL elements. Captures operand bases
// and vector flags on acceptance, issues one element per step, waits for
// exec_done between elements, and requests a PC advance after the last.
// Assumes exec_done is a single-cycle pulse per issued element.
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int NUM_DST = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dec_valid,
    input  logic [NUM_SRC-1:0]       src_vec,
    input  logic [NUM_DST-1:0]       dst_vec,
    input  logic [NUM_SRC*REG_W-1:0] src_base,
    input  logic [NUM_DST*REG_W-1:0] dst_base,
    input  logic                     st_wr_en,
    input  logic [STATE_W-1:0]       st_wr_data,
    input  logic                     exec_done,
    output logic                     issue,
    output logic [NUM_SRC*REG_W-1:0] src_reg,
    output logic [NUM_DST*REG_W-1:0] dst_reg,
    output logic [LEN_W-1:0]         cur_step,
    output logic                     pc_adv,
    output logic                     loop_done,
    output logic                     dst_all_scalar,
    output logic [STATE_W-1:0]       st_rd_data
);
    seq_state_e                seq_q;
    logic [NUM_SRC-1:0]        src_vec_q;
    logic [NUM_DST-1:0]        dst_vec_q;
    logic [NUM_SRC*REG_W-1:0]  src_base_q;
    logic [NUM_DST*REG_W-1:0]  dst_base_q;
    logic [LEN_W-1:0]          vl;
    logic [LEN_W-1:0]          mvl;
    logic [LEN_W-1:0]          step;
    logic                      last;
    logic                      accept;
    logic                      wr_ok;
    logic                      elem_done;
    logic                      step_adv;
    logic                      step_clr;

    // Handshake decode for the current sequencer state.
    always_comb begin
        accept    = (seq_q == SEQ_IDLE) && dec_valid;
        wr_ok     = (seq_q == SEQ_IDLE) && !dec_valid;
        elem_done = (seq_q == SEQ_WAIT) && exec_done;
        step_adv  = elem_done && !last;
        step_clr  = elem_done && last;
    end

    // Sequencer state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE;
        end else begin
            case (seq_q)
                SEQ_IDLE:   if (dec_valid) seq_q <= (vl == '0) ? SEQ_RETIRE : SEQ_ISSUE;
                SEQ_ISSUE:  seq_q <= SEQ_WAIT;
                SEQ_WAIT:   if (exec_done) seq_q <= last ? SEQ_RETIRE : SEQ_ISSUE;
                default:    seq_q <= SEQ_IDLE;
            endcase
        end
    end

    // Capture the accepted instruction's operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_vec_q  <= '0;
            dst_vec_q  <= '0;
            src_base_q <= '0;
            dst_base_q <= '0;
        end else if (accept) begin
            src_vec_q  <= src_vec;
            dst_vec_q  <= dst_vec;
            src_base_q <= src_base;
            dst_base_q <= dst_base;
        end
    end

    vseq_state_reg #(
        .STATE_W (STATE_W),
        .LEN_W   (LEN_W),
        .VL_LSB  (VL_LSB),
        .MVL_LSB (MVL_LSB)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_ok   (wr_ok),
        .wr_data (st_wr_data),
        .vl      (vl),
        .mvl     (mvl)
    );

    vseq_step_ctr #(
        .LEN_W (LEN_W)
    ) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (step_adv),
        .clear   (step_clr),
        .vl      (vl),
        .step    (step),
        .last    (last)
    );

    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_src
        vseq_reg_offset #(
            .REG_W (REG_W),
            .LEN_W (LEN_W)
        ) u_off (
            .base    (src_base_q[gs*REG_W +: REG_W]),
            .is_vec  (src_vec_q[gs]),
            .step    (step),
            .reg_num (src_reg[gs*REG_W +: REG_W])
        );
    end

    for (genvar gd = 0; gd < NUM_DST; gd++) begin : g_dst
        vseq_reg_offset #(
            .REG_W (REG_W),
            .LEN_W (LEN_W)
        ) u_off (
            .base    (dst_base_q[gd*REG_W +: REG_W]),
            .is_vec  (dst_vec_q[gd]),
            .step    (step),
            .reg_num (dst_reg[gd*REG_W +: REG_W])
        );
    end

    // Output strobes, flags and state readout assembly.
    always_comb begin
        issue          = (seq_q == SEQ_ISSUE);
        pc_adv         = (seq_q == SEQ_RETIRE);
        loop_done      = (seq_q == SEQ_RETIRE);
        cur_step       = step;
        dst_all_scalar = ~|dst_vec_q;
        st_rd_data     = '0;
        st_rd_data[VL_LSB   +: LEN_W] = vl;
        st_rd_data[MVL_LSB  +: LEN_W] = mvl;
        st_rd_data[STEP_LSB +: LEN_W] = step;
    end
endmodule

// File: rtl/vseq_checker.sv
// Module: vseq_checker
// Temporal checks on the sequencer, bound to every vec_elem_seq instance.
module vseq_checker
    import vseq_pkg::*;
#(
    parameter int NUM_DST = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     dec_valid,
    input logic                     exec_done,
    input logic                     seq_idle,
    input logic                     issue,
    input logic                     pc_adv,
    input logic                     loop_done,
    input logic [LEN_W-1:0]         cur_step,
    input logic [LEN_W-1:0]         vl,
    input logic [NUM_DST-1:0]       dst_vec_q,
    input logic [NUM_DST*REG_W-1:0] dst_base_q,
    input logic [NUM_DST*REG_W-1:0] dst_reg
);
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (cur_step < vl)); // R5
    AST_STEP_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_step) |-> $past(exec_done)); // R5
    AST_ZERO_LEN_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && dec_valid && (vl == '0)) |=> (pc_adv && !issue)); // R7
    AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue); // R4
    AST_NO_ISSUE_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && pc_adv)); // R4
    AST_RETIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv |-> ($past(exec_done) || $past(seq_idle && dec_valid))); // R8
    AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_adv && loop_done) |=> !pc_adv); // R8
    AST_RETIRE_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv |-> (cur_step == '0)); // R8
    AST_SCALAR_DST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !dst_vec_q[0]) |-> (dst_reg[REG_W-1:0] == dst_base_q[REG_W-1:0])); // R6
endmodule

bind vec_elem_seq vseq_checker #(.NUM_DST(NUM_DST)) u_vseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .exec_done  (exec_done),
    .seq_idle   (seq_q == vseq_pkg::SEQ_IDLE),
    .issue      (issue),
    .pc_adv     (pc_adv),
    .loop_done  (loop_done),
    .cur_step   (cur_step),
    .vl         (vl),
    .dst_vec_q  (dst_vec_q),
    .dst_base_q (dst_base_q),
    .dst_reg    (dst_reg)
);

// File: tb/test_vec_elem_seq.sv
// Directed bench for vec_elem_seq: one task per scenario.
module test_vec_elem_seq;
    localparam int NS = 3;
    localparam int ND = 2;
    localparam int RW = 7;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dec_valid;
    logic [NS-1:0]   src_vec;
    logic [ND-1:0]   dst_vec;
    logic [NS*RW-1:0] src_base;
    logic [ND*RW-1:0] dst_base;
    logic            st_wr_en;
    logic [31:0]     st_wr_data;
    logic            exec_done;
    logic            issue;
    logic [NS*RW-1:0] src_reg;
    logic [ND*RW-1:0] dst_reg;
    logic [6:0]      cur_step;
    logic            pc_adv;
    logic            loop_done;
    logic            dst_all_scalar;
    logic [31:0]     st_rd_data;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vec_elem_seq #(.NUM_SRC(NS), .NUM_DST(ND)) i_vec_elem_seq (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .src_vec(src_vec),
        .dst_vec(dst_vec), .src_base(src_base), .dst_base(dst_base),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .exec_done(exec_done),
        .issue(issue), .src_reg(src_reg), .dst_reg(dst_reg), .cur_step(cur_step),
        .pc_adv(pc_adv), .loop_done(loop_done), .dst_all_scalar(dst_all_scalar),
        .st_rd_data(st_rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_state(input int vl, input int mvl, input int stp);
        st_wr_en   = 1'b1;
        st_wr_data = (stp << 16) | (mvl << 8) | vl;
        tick();
        st_wr_en   = 1'b0;
    endtask

    // Run a full loop, checking every element; poke injects busy stimulus.
    task automatic run_loop(input int vl, input logic [NS-1:0] sv, input logic [ND-1:0] dv,
                            input logic [NS*RW-1:0] sb, input logic [ND*RW-1:0] db,
                            input int gap, input bit poke);
        src_vec = sv; dst_vec = dv; src_base = sb; dst_base = db;
        dec_valid = 1'b1;
        tick();
        dec_valid = 1'b0;
        src_base = '0; dst_base = '0; src_vec = '0; dst_vec = '0;
        for (int k = 0; k < vl; k++) begin
            chk("R4 issue high", issue, 1);
            chk("R5 step value", cur_step, k);
            chk("R9 scalar flag", dst_all_scalar, (dv == 0) ? 1 : 0);
            for (int o = 0; o < NS; o++)
                chk("R6 src reg", src_reg[o*RW +: RW], (sb[o*RW +: RW] + (sv[o] ? k : 0)) % 128);
            for (int o = 0; o < ND; o++)
                chk("R6 dst reg", dst_reg[o*RW +: RW], (db[o*RW +: RW] + (dv[o] ? k : 0)) % 128);
            if (poke) begin
                exec_done = 1'b1; dec_valid = 1'b1; st_wr_en = 1'b1;
                st_wr_data = 32'h0000_1111;
                src_base = '1; src_vec = '1;
            end
            tick();
            exec_done = 1'b0; dec_valid = 1'b0; st_wr_en = 1'b0;
            src_base = '0; src_vec = '0;
            chk("R4 issue single", issue, 0);
            chk("R5 step holds", cur_step, k);
            for (int g = 0; g < gap; g++) begin
                tick();
                chk("R5 wait no move", cur_step, k);
                chk("R4 no issue while waiting", issue, 0);
            end
            exec_done = 1'b1;
            tick();
            exec_done = 1'b0;
        end
        chk("R8 pc_adv pulse", pc_adv, 1);
        chk("R8 loop_done pulse", loop_done, 1);
        chk("R8 step back to zero", cur_step, 0);
        chk("R4 no issue at retire", issue, 0);
        tick();
        chk("R8 pc_adv one cycle", pc_adv, 0);
        chk("R8 idle after retire", issue, 0);
    endtask

    task automatic t_reset();
        chk("R1 issue", issue, 0);
        chk("R1 pc_adv", pc_adv, 0);
        chk("R1 loop_done", loop_done, 0);
        chk("R1 step", cur_step, 0);
        chk("R1 state", st_rd_data, 0);
    endtask

    task automatic t_state_write();
        write_state(5, 9, 127);
        chk("R2 layout, step bits ignored", st_rd_data, (9 << 8) | 5);
    endtask

    task automatic t_short_loop();
        write_state(3, 64, 0);
        run_loop(3, 3'b101, 2'b01, {7'd126, 7'd20, 7'd10}, {7'd50, 7'd40}, 2, 1'b0);
    endtask

    task automatic t_busy_ignore();
        write_state(2, 64, 0);
        run_loop(2, 3'b010, 2'b10, {7'd3, 7'd4, 7'd5}, {7'd6, 7'd7}, 1, 1'b1);
        chk("R3 busy write dropped", st_rd_data, (64 << 8) | 2);
        exec_done = 1'b1;
        tick();
        exec_done = 1'b0;
        chk("R5 idle exec_done ignored issue", issue, 0);
        chk("R5 idle exec_done ignored step", cur_step, 0);
        chk("R10 idle after busy dec_valid", pc_adv, 0);
    endtask

    task automatic t_single_scalar();
        write_state(1, 64, 0);
        run_loop(1, 3'b000, 2'b00, {7'd1, 7'd2, 7'd3}, {7'd4, 7'd5}, 0, 1'b0);
    endtask

    task automatic t_zero_len();
        write_state(0, 64, 0);
        dec_valid = 1'b1;
        tick();
        dec_valid = 1'b0;
        chk("R7 no issue", issue, 0);
        chk("R7 pc_adv", pc_adv, 1);
        chk("R7 loop_done", loop_done, 1);
        tick();
        chk("R7 pulse ends", pc_adv, 0);
        chk("R7 still no issue", issue, 0);
    endtask

    task automatic t_full_len();
        write_state(127, 127, 0);
        run_loop(127, 3'b111, 2'b11, {7'd127, 7'd1, 7'd0}, {7'd100, 7'd64}, 0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dec_valid = 1'b0; src_vec = '0; dst_vec = '0;
        src_base = '0; dst_base = '0; st_wr_en = 1'b0; st_wr_data = '0;
        exec_done = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_state_write();
        t_short_loop();
        t_busy_ignore();
        t_single_scalar();
        t_zero_len();
        t_full_len();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule